// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the command pins of a single-data-rate SDRAM from reset until the device is idle with its mode register loaded. It first holds the bus at NOP for a power-up settling time of 200 us, counted in clock cycles from the clock frequency. This is twice the usual device minimum, so it is safe for parts that ask for more. It then issues the fixed bring-up sequence. Each real command occupies a single clock, and every cycle between commands carries NOP.

The sequence is one all-bank precharge, a gap of tRP, an auto refresh, a gap of tRC, a second auto refresh and another tRC gap. After that comes a mode-register load whose address-line value is assembled from the burst length, burst type, CAS latency and write-burst mode parameters. Once tMRD has elapsed after the load, a done flag rises and stays high. The main memory controller takes over the pins at that point, and only then may it issue an ACTIVE. All timing values are whole clock cycles set by parameters.

Top module: `sdram_init_seq`

## Requirements
- R1: While rst_ni is low, and for exactly PWRUP_CYC = CLK_MHZ*PWRUP_US rising edges after its release, the command {cs_n,ras_n,cas_n,we_n} is NOP (4'b0111) and done_o is 0.
- R2: The first non-NOP command is PRECHARGE (4'b0010) with addr_o[10]=1, all other address bits 0 and ba_o=0. It appears after rising edge number PWRUP_CYC following reset release.
- R3: The first AUTO REFRESH (4'b0001, address and bank 0) appears TRP_CYC cycles after the precharge. The second appears TRC_CYC cycles after the first.
- R4: LOAD MODE (4'b0000) appears TRC_CYC cycles after the second refresh, with ba_o=0 and the following fields on the address lines. addr_o[2:0] holds log2 of BURST_LEN (1,2,4,8 → 0..3). addr_o[3] holds BURST_TYPE (0 sequential). addr_o[6:4] holds CAS_LAT. addr_o[9] holds WRITE_SINGLE (1 = single-location writes). Every other bit is 0. The defaults give 12'h032; BURST_LEN=8, BURST_TYPE=1, CAS_LAT=2, WRITE_SINGLE=1 give 12'h22B.
- R5: Each command lasts one cycle, and NOP is driven on every other cycle. Exactly four non-NOP commands occur per sequence.
- R6: done_o rises TMRD_CYC cycles after the mode load and stays high, with NOP on the pins, until reset.
- R7: cke_o is 1 at all times, including during reset.
- R8: Asserting rst_ni low at any point, including during a command cycle or after done_o is high, forces NOP and done_o=0 at once. After release the full sequence repeats, starting with the whole power-up wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_o | output | 1 | Clock enable to the SDRAM, held high |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ADDR_W | Address lines; A10 selects all banks on precharge; carries the mode word on load |
| done_o | output | 1 | Initialization complete, controller may take over |

## Verification
The case most likely to go wrong is an asynchronous reset landing in the same cycle as a sequencer command. The bench provokes it twice. It drops reset while the second auto refresh is on the pins, and again after done has risen. In both cases it expects NOP and a low done flag within the same half cycle, and it expects the whole power-up wait and the command order to replay with unchanged gaps. A cycle-by-cycle comparison against a model computed from the parameters runs alongside. It covers two parameter sets, one at full 200 us length and one short, so that a stray, early or long command is caught.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } cmd_e;

  typedef enum logic [3:0] {
    ST_PWRUP,
    ST_PRE,
    ST_TRP,
    ST_REF1,
    ST_TRC1,
    ST_REF2,
    ST_TRC2,
    ST_LMR,
    ST_TMRD,
    ST_DONE
  } state_e;

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int unsigned W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= RST_VAL;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // count never jumps upward without a load
  AST_TMR_NO_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (cnt_q <= $past(cnt_q)));  // R5

endmodule

// File: rtl/sdram_mode_word.sv
module sdram_mode_word #(
  parameter int unsigned ADDR_W       = 12,
  parameter int unsigned BURST_LEN    = 4,
  parameter int unsigned BURST_TYPE   = 0,
  parameter int unsigned CAS_LAT      = 3,
  parameter int unsigned WRITE_SINGLE = 0
) (
  output logic [ADDR_W-1:0] word_o
);

  localparam int unsigned BL_CODE = $clog2(BURST_LEN);

  always_comb begin
    word_o      = '0;
    word_o[2:0] = 3'(BL_CODE);
    word_o[3]   = 1'(BURST_TYPE);
    word_o[6:4] = 3'(CAS_LAT);
    word_o[9]   = 1'(WRITE_SINGLE);
  end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int unsigned CLK_MHZ      = 100,
  parameter int unsigned PWRUP_US     = 200,
  parameter int unsigned TRP_CYC      = 2,
  parameter int unsigned TRC_CYC      = 7,
  parameter int unsigned TMRD_CYC     = 2,
  parameter int unsigned BURST_LEN    = 4,
  parameter int unsigned BURST_TYPE   = 0,
  parameter int unsigned CAS_LAT      = 3,
  parameter int unsigned WRITE_SINGLE = 0,
  parameter int unsigned ADDR_W       = 12,
  parameter int unsigned BA_W         = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o
);

  localparam int unsigned PWRUP_CYC = CLK_MHZ * PWRUP_US;
  localparam int unsigned TMR_W     = $clog2(PWRUP_CYC + 1);
  localparam int unsigned ALL_BANK  = 10;
  localparam logic [TMR_W-1:0] LD_PWRUP = TMR_W'(PWRUP_CYC - 1);
  // wait states hold gap-1 cycles; the command cycle is the first one
  localparam logic [TMR_W-1:0] LD_TRP  = TMR_W'((TRP_CYC  > 1) ? TRP_CYC  - 2 : 0);
  localparam logic [TMR_W-1:0] LD_TRC  = TMR_W'((TRC_CYC  > 1) ? TRC_CYC  - 2 : 0);
  localparam logic [TMR_W-1:0] LD_TMRD = TMR_W'((TMRD_CYC > 1) ? TMRD_CYC - 2 : 0);

  state_e             state_q, state_d;
  cmd_e               cmd;
  logic               tmr_load, tmr_zero;
  logic [TMR_W-1:0]   tmr_val;
  logic [ADDR_W-1:0]  mode_word;

  sdram_init_timer #(
    .W       (TMR_W),
    .RST_VAL (LD_PWRUP)
  ) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  sdram_mode_word #(
    .ADDR_W       (ADDR_W),
    .BURST_LEN    (BURST_LEN),
    .BURST_TYPE   (BURST_TYPE),
    .CAS_LAT      (CAS_LAT),
    .WRITE_SINGLE (WRITE_SINGLE)
  ) i_mode (
    .word_o (mode_word)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    cmd      = CMD_NOP;
    addr_o   = '0;
    done_o   = 1'b0;
    unique case (state_q)
      ST_PWRUP: if (tmr_zero) state_d = ST_PRE;
      ST_PRE: begin
        cmd              = CMD_PRE;
        addr_o[ALL_BANK] = 1'b1;
        tmr_load         = 1'b1;
        tmr_val          = LD_TRP;
        state_d          = (TRP_CYC > 1) ? ST_TRP : ST_REF1;
      end
      ST_TRP:  if (tmr_zero) state_d = ST_REF1;
      ST_REF1: begin
        cmd      = CMD_REF;
        tmr_load = 1'b1;
        tmr_val  = LD_TRC;
        state_d  = (TRC_CYC > 1) ? ST_TRC1 : ST_REF2;
      end
      ST_TRC1: if (tmr_zero) state_d = ST_REF2;
      ST_REF2: begin
        cmd      = CMD_REF;
        tmr_load = 1'b1;
        tmr_val  = LD_TRC;
        state_d  = (TRC_CYC > 1) ? ST_TRC2 : ST_LMR;
      end
      ST_TRC2: if (tmr_zero) state_d = ST_LMR;
      ST_LMR: begin
        cmd      = CMD_LMR;
        addr_o   = mode_word;
        tmr_load = 1'b1;
        tmr_val  = LD_TMRD;
        state_d  = (TMRD_CYC > 1) ? ST_TMRD : ST_DONE;
      end
      ST_TMRD: if (tmr_zero) state_d = ST_DONE;
      ST_DONE: done_o = 1'b1;
      default: state_d = ST_PWRUP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_PWRUP;
    else         state_q <= state_d;
  end

  assign cke_o = 1'b1;
  assign ba_o  = '0;
  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd;

  // gap tracker for the timing assertions
  localparam int unsigned GAP_W = TMR_W + 1;
  localparam logic [GAP_W-1:0] GAP_MAX = '1;
  localparam logic [GAP_W-1:0] G_PWRUP = GAP_W'(PWRUP_CYC);
  localparam logic [GAP_W-1:0] G_TRP   = GAP_W'(TRP_CYC);
  localparam logic [GAP_W-1:0] G_TRC   = GAP_W'(TRC_CYC);
  localparam logic [GAP_W-1:0] G_TMRD  = GAP_W'(TMRD_CYC);

  logic [3:0]       pin_cmd;
  logic [3:0]       last_q;
  logic [GAP_W-1:0] gap_q;
  assign pin_cmd = {cs_n_o, ras_n_o, cas_n_o, we_n_o};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= 4'b0111;
      gap_q  <= '0;
    end else if (pin_cmd != 4'b0111) begin
      last_q <= pin_cmd;
      gap_q  <= GAP_W'(1);
    end else if (gap_q != GAP_MAX) begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  AST_ONE_CYCLE_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_cmd != 4'b0111) |=> (pin_cmd == 4'b0111));  // R5
  AST_PRE_AFTER_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_cmd == 4'b0010) |-> (last_q == 4'b0111 && gap_q >= G_PWRUP && addr_o[ALL_BANK]));  // R2
  AST_REF_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_cmd == 4'b0001) |-> ((last_q == 4'b0010 && gap_q >= G_TRP) ||
                              (last_q == 4'b0001 && gap_q >= G_TRC)));  // R3
  AST_LMR_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_cmd == 4'b0000) |-> (last_q == 4'b0001 && gap_q >= G_TRC && ba_o == '0));  // R4
  AST_DONE_LATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (last_q == 4'b0000 && gap_q >= G_TMRD));  // R6
  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (done_o && pin_cmd == 4'b0111));  // R6

endmodule

// File: tb/test_sdram_init_seq.sv
module test_sdram_init_seq;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = CLK_PERIOD / 4;
  localparam int WD_CYC     = 150000;

  // main instance: defaults
  localparam int P    = 100 * 200;
  localparam int TRP  = 2;
  localparam int TRC  = 7;
  localparam int TMRD = 2;
  localparam int L    = P + TRP + 2 * TRC;
  // alternate instance
  localparam int AP    = 1 * 50;
  localparam int ATRP  = 3;
  localparam int ATRC  = 5;
  localparam int ATMRD = 3;
  localparam int AL    = AP + ATRP + 2 * ATRC;

  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, LMR = 4'b0000;

  typedef struct packed {
    int          cyc;
    logic [3:0]  cmd;
    logic [11:0] addr;
    logic        done;
    logic [15:0] tag;
  } row_t;

  localparam int NROW = 9;
  localparam row_t TBL [NROW] = '{
    '{P - 1,          NOP, 12'h000, 1'b0, "R1"},
    '{P,              PRE, 12'h400, 1'b0, "R2"},
    '{P + 1,          NOP, 12'h000, 1'b0, "R5"},
    '{P + TRP,        REF, 12'h000, 1'b0, "R3"},
    '{P + TRP + TRC,  REF, 12'h000, 1'b0, "R3"},
    '{L,              LMR, 12'h032, 1'b0, "R4"},
    '{L + TMRD - 1,   NOP, 12'h000, 1'b0, "R6"},
    '{L + TMRD,       NOP, 12'h000, 1'b1, "R6"},
    '{L + TMRD + 5,   NOP, 12'h000, 1'b1, "R6"}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   cyc;
  int   total = 0;
  int   bad = 0;
  int   mism_main = 0;
  int   mism_alt = 0;
  bit   fin = 1'b0;

  logic        cke, cs_n, ras_n, cas_n, we_n, done;
  logic [1:0]  ba;
  logic [11:0] addr;
  logic        a_cke, a_cs_n, a_ras_n, a_cas_n, a_we_n, a_done;
  logic [1:0]  a_ba;
  logic [11:0] a_addr;

  always #(CLK_PERIOD / 2) clk = ~clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  sdram_init_seq i_sdram_init_seq (
    .clk_i (clk), .rst_ni (rst_n), .cke_o (cke), .cs_n_o (cs_n),
    .ras_n_o (ras_n), .cas_n_o (cas_n), .we_n_o (we_n),
    .ba_o (ba), .addr_o (addr), .done_o (done)
  );

  sdram_init_seq #(
    .CLK_MHZ (1), .PWRUP_US (50), .TRP_CYC (ATRP), .TRC_CYC (ATRC),
    .TMRD_CYC (ATMRD), .BURST_LEN (8), .BURST_TYPE (1), .CAS_LAT (2),
    .WRITE_SINGLE (1)
  ) i_alt (
    .clk_i (clk), .rst_ni (rst_n), .cke_o (a_cke), .cs_n_o (a_cs_n),
    .ras_n_o (a_ras_n), .cas_n_o (a_cas_n), .we_n_o (a_we_n),
    .ba_o (a_ba), .addr_o (a_addr), .done_o (a_done)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h (cyc=%0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [4:0] model(input int c, input int p, input int trp,
                                       input int trc, input int tmrd, input bit rst);
    logic [3:0] k;
    k = NOP;
    if (!rst) begin
      if (c == p) k = PRE;
      else if (c == p + trp || c == p + trp + trc) k = REF;
      else if (c == p + trp + 2 * trc) k = LMR;
    end
    return {(!rst && c >= p + trp + 2 * trc + tmrd), k};
  endfunction

  // cycle-by-cycle comparison for both instances (R5, R7) and alt spot checks
  always @(negedge clk) begin
    if (!fin) begin
      if ({cke, done, cs_n, ras_n, cas_n, we_n} != {1'b1, model(cyc, P, TRP, TRC, TMRD, !rst_n)}) begin
        if (mism_main < 4) $display("main mismatch at cyc=%0d", cyc);
        mism_main++;
      end
      if ({a_cke, a_done, a_cs_n, a_ras_n, a_cas_n, a_we_n} != {1'b1, model(cyc, AP, ATRP, ATRC, ATMRD, !rst_n)}) begin
        if (mism_alt < 4) $display("alt mismatch at cyc=%0d", cyc);
        mism_alt++;
      end
      if (rst_n && cyc == AP)
        chk({a_cs_n, a_ras_n, a_cas_n, a_we_n} == PRE && a_addr == 12'h400, "R2 alt precharge",
            {a_cs_n, a_ras_n, a_cas_n, a_we_n, a_addr}, {PRE, 12'h400});
      if (rst_n && cyc == AL)
        chk({a_cs_n, a_ras_n, a_cas_n, a_we_n} == LMR && a_addr == 12'h22B && a_ba == 2'b00,
            "R4 alt mode word", {a_cs_n, a_ras_n, a_cas_n, a_we_n, a_ba, a_addr}, {LMR, 2'b00, 12'h22B});
      if (rst_n && cyc == AL + ATMRD)
        chk(a_done == 1'b1, "R6 alt done", a_done, 1);
    end
  end

  task automatic walk_table(input string pass);
    for (int i = 0; i < NROW; i++) begin
      while (cyc != TBL[i].cyc) @(negedge clk);
      chk({cs_n, ras_n, cas_n, we_n, addr, ba, done, cke} ==
          {TBL[i].cmd, TBL[i].addr, 2'b00, TBL[i].done, 1'b1},
          $sformatf("%s %s row%0d", string'(TBL[i].tag), pass, i),
          {cs_n, ras_n, cas_n, we_n, addr, ba, done, cke},
          {TBL[i].cmd, TBL[i].addr, 2'b00, TBL[i].done, 1'b1});
    end
  endtask

  task automatic release_reset();
    @(negedge clk);
    #Q rst_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 / R7: reset state
    chk({cs_n, ras_n, cas_n, we_n} == NOP && !done, "R1 reset state", {cs_n, ras_n, cas_n, we_n, done}, {NOP, 1'b0});
    chk(cke && a_cke, "R7 cke in reset", {cke, a_cke}, 2'b11);
    release_reset();

    walk_table("pass1");

    // R8: reset while done is high
    @(negedge clk);
    #Q rst_n = 1'b0;
    #1;
    chk(!done && {cs_n, ras_n, cas_n, we_n} == NOP, "R8 reset after done",
        {done, cs_n, ras_n, cas_n, we_n}, {1'b0, NOP});
    chk(cke, "R7 cke at reset", cke, 1);
    repeat (2) @(negedge clk);
    release_reset();

    // R8: reset landing on the second refresh cycle
    while (cyc != P + TRP + TRC) @(negedge clk);
    chk({cs_n, ras_n, cas_n, we_n} == REF, "R3 second refresh before reset", {cs_n, ras_n, cas_n, we_n}, REF);
    #Q rst_n = 1'b0;
    #1;
    chk({cs_n, ras_n, cas_n, we_n} == NOP && !done, "R8 reset during command",
        {cs_n, ras_n, cas_n, we_n, done}, {NOP, 1'b0});
    repeat (2) @(negedge clk);
    release_reset();

    walk_table("pass2");

    chk(mism_main == 0, "R5 main stray cycles", mism_main, 0);
    chk(mism_alt == 0, "R5 alt stray cycles", mism_alt, 0);
    fin = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!fin) begin
      fin = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog R6 act=%0d exp=done", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule